// File: doc/BRIEF.md
# Display Interrupt Status Unit

This block gathers event pulses from a display controller's DMA channels into two sticky status registers and drives a single level-sensitive interrupt. Channel 0 is the main plane; its flags sit in status register 0 together with controller-wide events such as frame-done, AC-bias count, output underrun, read-status and command completion. Channels 1 and above are auxiliary planes whose start-of-frame, end-of-frame, branch and underrun flags sit in status register 1. Each interrupt source has a mask bit. The interrupt output stays high while any unmasked flag is set.

When an unmasked start-of-frame, end-of-frame or branch event arrives, or any bus-error event arrives, the block checks the interrupt line. If the line is low, the frame identifier that the DMA supplies for that channel is latched into an identification register, so the handler sees which frame caused the interrupt. If the line is already high, a sticky "subsequent event" flag is set and the latched identifier is left unchanged. Software clears flags by writing ones. A control write that drops the enable bit raises a quick-disable flag.

Top module: `disp_irq_status`

## Requirements
- R1: After synchronous reset, both status registers, the identification register, the control enable, both mask registers and `irq` are 0.
- R2: A pulse on a status-0 event input sets its flag on the next clock edge. The flags are: bit0 frame-done (`done_ev`), bit1 main start-of-frame, bit2 bus error, bit3 AC-bias (`acb_ev`), bit4 main underrun, bit5 channel-1 underrun, bit6 output underrun (`oun_ev`), bit7 quick-disable, bit8 main end-of-frame, bit9 main branch, bit10 subsequent event, bit11 read-status (`rds_ev`), bit12 command done (`cmd_ev`).
- R3: For auxiliary channel k (k >= 1), status register 1 uses bit k-1 for start-of-frame, k+7 for end-of-frame, k+15 for branch and k+23 for underrun. A channel-1 underrun also sets status-0 bit5.
- R4: `irq` is high exactly when at least one of these holds: a status-0 flag in bits {0,1,4,5,6,7,8,9,11,12} is set and its mask0 bit at the same position is 0; status-0 bit2 is set; a status-1 flag is set and its mask1 bit at the same position is 0. Bits 3 and 10 never drive `irq`. Changing a mask changes `irq` with no event.
- R5: When a qualifying event (an unmasked start-of-frame, end-of-frame or branch, or any bus error) arrives while `irq` is low, the identification register loads the frame ID of the lowest-numbered qualifying channel, and bit10 stays clear.
- R6: When a qualifying event arrives while `irq` is high, status-0 bit10 is set and the identification register keeps its value.
- R7: A bus error cannot be masked. It sets status-0 bit2, drives `irq` high even with every mask bit set, and writes the lowest erroring channel number into read bits 30:28 of status 0.
- R8: Writing status 0 clears each flag in bits 11:0 that is written as 1. Bit12 is not cleared. A 1 in bit2 also clears the channel field in bits 30:28.
- R9: Writing status 1 clears only the flags selected by 0x003E3F3F. Any other set flag, such as channel-1 branch at bit16, stays set.
- R10: A control write with data bit0 = 0 while the enable is 1 sets status-0 bit7. The same write while the enable is already 0 leaves bit7 clear.
- R11: An event that arrives in the same cycle as a clearing write to its flag wins, and the flag stays set.
- R12: Register addresses are 0 control (bit0 enable), 1 mask0 (writable bits 0x1BF3), 2 mask1 (writable bits 0x3F3F3F3F), 3 status 0, 4 status 1 and 5 identification. `rd_data` shows the register at `addr` one clock edge after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| sof_ev | input | NCH | Start-of-frame pulse for each channel |
| eof_ev | input | NCH | End-of-frame pulse for each channel |
| brn_ev | input | NCH | Branch-taken pulse for each channel |
| ber_ev | input | NCH | Bus-error pulse for each channel |
| und_ev | input | NCH | Input-underrun pulse for each channel |
| done_ev | input | 1 | Last-frame-done pulse |
| acb_ev | input | 1 | AC-bias count pulse |
| oun_ev | input | 1 | Output-underrun pulse |
| rds_ev | input | 1 | Read-status pulse |
| cmd_ev | input | 1 | Command-done pulse |
| frame_id | input | NCH*FID_W | Current frame ID of each channel, channel 0 in the low slice |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
A vector table fires one event per vector. Across the vectors the channel, the event kind, whether the source is masked and whether `irq` was already high are varied. These cases separate three outcomes: loading the identifier, setting the subsequent flag, and a silent masked set. Directed cases then cover the register-file details. Two channels fire in the same cycle to test the lowest-index choice, and an event meets a clearing write in the same cycle. Other cases write ones to the clear-protected bits of both status registers, drop the enable once from 1 and once from 0, and toggle a mask to show that `irq` follows the mask level.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  // status register 0 bit positions
  localparam int S0_DONE = 0;
  localparam int S0_SOF  = 1;
  localparam int S0_BER  = 2;
  localparam int S0_ACB  = 3;
  localparam int S0_UND0 = 4;
  localparam int S0_UND1 = 5;
  localparam int S0_OUN  = 6;
  localparam int S0_QDIS = 7;
  localparam int S0_EOF  = 8;
  localparam int S0_BRN  = 9;
  localparam int S0_SUBQ = 10;
  localparam int S0_RDS  = 11;
  localparam int S0_CMD  = 12;
  localparam int S0_W    = 13;

  // status register 1 field bases (channel k lands at base + k)
  localparam int S1_SOF_BASE = -1;
  localparam int S1_EOF_BASE = 7;
  localparam int S1_BRN_BASE = 15;
  localparam int S1_UND_BASE = 23;

  // interrupt-driving, maskable flags in status 0
  localparam logic [S0_W-1:0] S0_IRQ_SRC   = 13'h1BF3;
  // write-one-to-clear reach of status 0
  localparam logic [S0_W-1:0] S0_CLR_REACH = 13'h0FFF;
  // write-one-to-clear reach of status 1
  localparam logic [31:0]     S1_CLR_REACH = 32'h003E_3F3F;
  // writable mask1 bits
  localparam logic [31:0]     M1_WMASK     = 32'h3F3F_3F3F;

  // bus-error channel field inside read view of status 0
  localparam int BERF_LSB = 28;
  localparam int BERF_W   = 3;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_MASK0 = 3'd1,
    RA_MASK1 = 3'd2,
    RA_STAT0 = 3'd3,
    RA_STAT1 = 3'd4,
    RA_FID   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/disp_irq_evt_map.sv
// Spreads per-channel event pulses onto status bit positions and flags the
// events that are allowed to touch the identification register.
module disp_irq_evt_map
  import disp_irq_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic [NCH-1:0]  sof,
  input  logic [NCH-1:0]  eof,
  input  logic [NCH-1:0]  brn,
  input  logic [NCH-1:0]  ber,
  input  logic [NCH-1:0]  und,
  input  logic [S0_W-1:0] mask0,
  input  logic [31:0]     mask1,
  output logic [S0_W-1:0] set0_ch,
  output logic [31:0]     set1,
  output logic [NCH-1:0]  qual
);
  // main channel (index 0)
  always_comb begin
    set0_ch          = '0;
    set0_ch[S0_SOF]  = sof[0];
    set0_ch[S0_EOF]  = eof[0];
    set0_ch[S0_BRN]  = brn[0];
    set0_ch[S0_UND0] = und[0];
    set0_ch[S0_UND1] = und[1];
  end

  assign qual[0] = ber[0]
                 | (sof[0] & ~mask0[S0_SOF])
                 | (eof[0] & ~mask0[S0_EOF])
                 | (brn[0] & ~mask0[S0_BRN]);

  // auxiliary channels
  logic [31:0] aux_bits [NCH];
  assign aux_bits[0] = '0;

  for (genvar k = 1; k < NCH; k++) begin : g_aux
    localparam int PS = S1_SOF_BASE + k;
    localparam int PE = S1_EOF_BASE + k;
    localparam int PB = S1_BRN_BASE + k;
    localparam int PU = S1_UND_BASE + k;
    always_comb begin
      aux_bits[k]     = aux_bits[k-1];
      aux_bits[k][PS] = aux_bits[k-1][PS] | sof[k];
      aux_bits[k][PE] = aux_bits[k-1][PE] | eof[k];
      aux_bits[k][PB] = aux_bits[k-1][PB] | brn[k];
      aux_bits[k][PU] = aux_bits[k-1][PU] | und[k];
    end
    assign qual[k] = ber[k]
                   | (sof[k] & ~mask1[PS])
                   | (eof[k] & ~mask1[PE])
                   | (brn[k] & ~mask1[PB]);
  end

  assign set1 = aux_bits[NCH-1];
endmodule

// File: rtl/disp_irq_first.sv
// Lowest-index-wins selector.
module disp_irq_first #(
  parameter int N  = 7,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/disp_irq_level.sv
// Interrupt level from registered flags and masks.
module disp_irq_level
  import disp_irq_pkg::*;
(
  input  logic [S0_W-1:0] st0,
  input  logic [S0_W-1:0] mask0,
  input  logic [31:0]     st1,
  input  logic [31:0]     mask1,
  output logic            irq
);
  logic main_hit, aux_hit;
  assign main_hit = |(st0 & ~mask0 & S0_IRQ_SRC);
  assign aux_hit  = |(st1 & ~mask1);
  assign irq      = main_hit | st0[S0_BER] | aux_hit;
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int NCH   = 7,
  parameter int FID_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [NCH-1:0]       sof_ev,
  input  logic [NCH-1:0]       eof_ev,
  input  logic [NCH-1:0]       brn_ev,
  input  logic [NCH-1:0]       ber_ev,
  input  logic [NCH-1:0]       und_ev,
  input  logic                 done_ev,
  input  logic                 acb_ev,
  input  logic                 oun_ev,
  input  logic                 rds_ev,
  input  logic                 cmd_ev,
  input  logic [NCH*FID_W-1:0] frame_id,
  output logic                 irq
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic              en_q;
  logic [S0_W-1:0]   mask0_q;
  logic [31:0]       mask1_q;
  logic [S0_W-1:0]   st0_q;
  logic [31:0]       st1_q;
  logic [BERF_W-1:0] berch_q;
  logic [FID_W-1:0]  fid_q;

  // event spreading
  logic [S0_W-1:0] set0_ch;
  logic [31:0]     set1;
  logic [NCH-1:0]  qual;

  disp_irq_evt_map #(.NCH(NCH)) u_map (
    .sof(sof_ev), .eof(eof_ev), .brn(brn_ev), .ber(ber_ev), .und(und_ev),
    .mask0(mask0_q), .mask1(mask1_q),
    .set0_ch(set0_ch), .set1(set1), .qual(qual)
  );

  // who is first among qualifying events and among bus errors
  logic          q_any, b_any;
  logic [CW-1:0] q_idx, b_idx;

  disp_irq_first #(.N(NCH), .IW(CW)) u_qsel (.req(qual),   .any(q_any), .idx(q_idx));
  disp_irq_first #(.N(NCH), .IW(CW)) u_bsel (.req(ber_ev), .any(b_any), .idx(b_idx));

  disp_irq_level u_lvl (
    .st0(st0_q), .mask0(mask0_q), .st1(st1_q), .mask1(mask1_q), .irq(irq)
  );

  // write decode
  logic wr_ctrl, wr_m0, wr_m1, wr_s0, wr_s1;
  assign wr_ctrl = wr_en && (addr == RA_CTRL);
  assign wr_m0   = wr_en && (addr == RA_MASK0);
  assign wr_m1   = wr_en && (addr == RA_MASK1);
  assign wr_s0   = wr_en && (addr == RA_STAT0);
  assign wr_s1   = wr_en && (addr == RA_STAT1);

  logic            qdis, subq;
  logic [S0_W-1:0] set0, clr0, st0_d;
  logic [31:0]     clr1, st1_d;

  assign qdis = wr_ctrl && en_q && !wr_data[0];
  assign subq = q_any && irq;

  always_comb begin
    set0           = set0_ch;
    set0[S0_DONE]  = done_ev;
    set0[S0_BER]   = b_any;
    set0[S0_ACB]   = acb_ev;
    set0[S0_OUN]   = oun_ev;
    set0[S0_QDIS]  = qdis;
    set0[S0_SUBQ]  = subq;
    set0[S0_RDS]   = rds_ev;
    set0[S0_CMD]   = cmd_ev;
    clr0  = wr_s0 ? (wr_data[S0_W-1:0] & S0_CLR_REACH) : '0;
    clr1  = wr_s1 ? (wr_data & S1_CLR_REACH) : '0;
    // set wins over clear
    st0_d = (st0_q & ~clr0) | set0;
    st1_d = (st1_q & ~clr1) | set1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      mask0_q <= '0;
      mask1_q <= '0;
      st0_q   <= '0;
      st1_q   <= '0;
      berch_q <= '0;
      fid_q   <= '0;
    end else begin
      if (wr_ctrl) en_q    <= wr_data[0];
      if (wr_m0)   mask0_q <= wr_data[S0_W-1:0] & S0_IRQ_SRC;
      if (wr_m1)   mask1_q <= wr_data & M1_WMASK;
      st0_q <= st0_d;
      st1_q <= st1_d;
      if (b_any)
        berch_q <= BERF_W'(b_idx);
      else if (clr0[S0_BER])
        berch_q <= '0;
      if (q_any && !irq)
        fid_q <= frame_id[q_idx*FID_W +: FID_W];
    end
  end

  // registered read port
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL:  rd_mux[0] = en_q;
      RA_MASK0: rd_mux[S0_W-1:0] = mask0_q;
      RA_MASK1: rd_mux = mask1_q;
      RA_STAT0: begin
        rd_mux[S0_W-1:0] = st0_q;
        rd_mux[BERF_LSB +: BERF_W] = berch_q;
      end
      RA_STAT1: rd_mux = st1_q;
      RA_FID:   rd_mux = 32'(fid_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/disp_irq_status_chk.sv
module disp_irq_status_chk #(
  parameter int NCH   = 7,
  parameter int FID_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [31:0]      wr_data,
  input logic [NCH-1:0]   ber_ev,
  input logic             sof0,
  input logic             en_q,
  input logic             irq,
  input logic [12:0]      st0,
  input logic [31:0]      st1,
  input logic [FID_W-1:0] fid_q
);
  logic prst_q;
  always_ff @(posedge clk) begin
    prst_q <= rst;
    if (prst_q && !rst) begin
      // R1
      rst_quiet_chk: assert (!irq && st0 == '0 && st1 == '0);
    end
  end

  // R7
  ber_unmaskable_chk: assert property (@(posedge clk) disable iff (rst)
    (|ber_ev) |=> (st0[2] && irq));

  // R10
  quick_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && en_q && !wr_data[0]) |=> st0[7]);

  // R6
  subq_when_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st0[10]) |-> $past(irq));

  // R5
  fid_when_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fid_q) |-> !$past(irq));

  // R11
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sof0 |=> st0[1]);

  // R9
  protected_bit_chk: assert property (@(posedge clk) disable iff (rst)
    st1[16] |=> st1[16]);
endmodule

bind disp_irq_status disp_irq_status_chk #(.NCH(NCH), .FID_W(FID_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .ber_ev(ber_ev), .sof0(sof_ev[0]), .en_q(en_q), .irq(irq),
  .st0(st0_q), .st1(st1_q), .fid_q(fid_q)
);

// File: tb/sim_disp_irq_status.sv
module sim_disp_irq_status;
  localparam int CLK_NS = 10;
  localparam int NCH    = 7;
  localparam int FID_W  = 32;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 wr_en = 1'b0;
  logic [2:0]           addr = '0;
  logic [31:0]          wr_data = '0;
  logic [31:0]          rd_data;
  logic [NCH-1:0]       sof_ev = '0, eof_ev = '0, brn_ev = '0, ber_ev = '0, und_ev = '0;
  logic                 done_ev = 0, acb_ev = 0, oun_ev = 0, rds_ev = 0, cmd_ev = 0;
  logic [NCH*FID_W-1:0] frame_id;
  logic                 irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_NS/2) clk = ~clk;

  disp_irq_status #(.NCH(NCH), .FID_W(FID_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sof_ev(sof_ev), .eof_ev(eof_ev), .brn_ev(brn_ev),
    .ber_ev(ber_ev), .und_ev(und_ev), .done_ev(done_ev), .acb_ev(acb_ev),
    .oun_ev(oun_ev), .rds_ev(rds_ev), .cmd_ev(cmd_ev), .frame_id(frame_id),
    .irq(irq)
  );

  // {ch[2:0], kind[1:0], masked, irq_pre, st0, st1, fid, irq}
  // kind: 0 sof, 1 eof, 2 branch, 3 bus error
  localparam int NV = 8;
  localparam logic [103:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0000, 32'h0000_0100, 1'b1},
    {3'd3, 2'd1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0400, 32'h0000_0103, 1'b1},
    {3'd2, 2'd2, 1'b1, 1'b0, 32'h0000_0000, 32'h0002_0000, 32'h0000_0000, 1'b0},
    {3'd5, 2'd0, 1'b0, 1'b1, 32'h0000_0401, 32'h0000_0010, 32'h0000_0000, 1'b1},
    {3'd4, 2'd3, 1'b1, 1'b0, 32'h4000_0004, 32'h0000_0000, 32'h0000_0104, 1'b1},
    {3'd0, 2'd1, 1'b1, 1'b0, 32'h0000_0100, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {3'd6, 2'd2, 1'b0, 1'b1, 32'h0000_0401, 32'h0020_0000, 32'h0000_0000, 1'b1},
    {3'd1, 2'd1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0100, 32'h0000_0101, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic clear_ev();
    sof_ev = '0; eof_ev = '0; brn_ev = '0; ber_ev = '0; und_ev = '0;
    done_ev = 0; acb_ev = 0; oun_ev = 0; rds_ev = 0; cmd_ev = 0;
  endtask

  // kind: 0 sof 1 eof 2 branch 3 ber 4 underrun 5 done 6 acb 7 cmd
  task automatic set_ev(input int kind, input int ch);
    case (kind)
      0: sof_ev[ch] = 1'b1;
      1: eof_ev[ch] = 1'b1;
      2: brn_ev[ch] = 1'b1;
      3: ber_ev[ch] = 1'b1;
      4: und_ev[ch] = 1'b1;
      5: done_ev = 1'b1;
      6: acb_ev = 1'b1;
      default: cmd_ev = 1'b1;
    endcase
  endtask

  task automatic fire(input int kind, input int ch);
    @(negedge clk); set_ev(kind, ch);
    @(negedge clk); clear_ev();
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) frame_id[k*FID_W +: FID_W] = 32'h100 + k;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 register", d, 32'h0);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0]  ch;
      logic [1:0]  kind;
      logic        msk, pre, eirq;
      logic [31:0] es0, es1, efid;
      {ch, kind, msk, pre, es0, es1, efid, eirq} = VEC[v];
      do_reset();
      if (msk) begin
        if (kind == 2'd3) begin
          wr(3'd1, 32'hFFFF_FFFF);
          wr(3'd2, 32'hFFFF_FFFF);
        end else if (ch == 0) begin
          wr(3'd1, 32'h1 << ((kind == 2'd0) ? 1 : (kind == 2'd1) ? 8 : 9));
        end else begin
          wr(3'd2, 32'h1 << (int'(ch) - 1 + 8 * int'(kind)));
        end
      end
      if (pre) fire(5, 0);
      fire(int'(kind), int'(ch));
      chk("R4 R7 vector irq", 32'(irq), 32'(eirq));
      rd(3'd3, d); chk("R2 R6 R7 vector status0", d, es0);
      rd(3'd4, d); chk("R3 vector status1", d, es1);
      rd(3'd5, d); chk("R5 R6 vector frame id", d, efid);
    end

    // R10 enable drop from 0 and from 1
    do_reset();
    wr(3'd0, 32'h0);
    rd(3'd3, d); chk("R10 no drop from 0", d, 32'h0);
    wr(3'd0, 32'h1);
    rd(3'd0, d); chk("R12 control readback", d, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd3, d); chk("R10 quick disable", d, 32'h80);
    chk("R10 irq", 32'(irq), 32'h1);

    // R7 / R8 bus error field and clearing
    do_reset();
    fire(3, 3);
    rd(3'd3, d); chk("R7 error channel", d, 32'h3000_0004);
    wr(3'd3, 32'h4);
    rd(3'd3, d); chk("R8 clear error and field", d, 32'h0);
    fire(7, 0);
    wr(3'd3, 32'h1FFF);
    rd(3'd3, d); chk("R8 bit12 kept", d, 32'h1000);

    // R9 status1 clear reach
    do_reset();
    fire(0, 1);
    fire(2, 1);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R9 protected bit", d, 32'h0001_0000);
    chk("R9 irq", 32'(irq), 32'h1);

    // R11 set beats clear
    do_reset();
    @(negedge clk);
    sof_ev[0] = 1'b1; wr_en = 1'b1; addr = 3'd3; wr_data = 32'h2;
    @(negedge clk);
    clear_ev(); wr_en = 1'b0; wr_data = '0;
    rd(3'd3, d); chk("R11 collision", d, 32'h2);

    // R5 lowest channel wins, R3 layout
    do_reset();
    @(negedge clk); sof_ev[2] = 1'b1; sof_ev[5] = 1'b1;
    @(negedge clk); clear_ev();
    rd(3'd5, d); chk("R5 lowest channel", d, 32'h102);
    rd(3'd3, d); chk("R5 no subsequent flag", d, 32'h0);
    rd(3'd4, d); chk("R3 two channels", d, 32'h12);

    // R4 mask level
    do_reset();
    wr(3'd1, 32'h1);
    fire(5, 0);
    chk("R4 masked done", 32'(irq), 32'h0);
    rd(3'd3, d); chk("R2 done flag", d, 32'h1);
    wr(3'd1, 32'h0);
    chk("R4 unmask raises", 32'(irq), 32'h1);

    // R3 underrun ch1, R4 acb not a source
    do_reset();
    fire(4, 1);
    rd(3'd3, d); chk("R3 underrun status0", d, 32'h20);
    rd(3'd4, d); chk("R3 underrun status1", d, 32'h0100_0000);
    do_reset();
    fire(6, 0);
    rd(3'd3, d); chk("R2 acb flag", d, 32'h8);
    chk("R4 acb no irq", 32'(irq), 32'h0);

    // R12 mask writable bits
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R12 mask1", d, 32'h3F3F_3F3F);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R12 mask0", d, 32'h1BF3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule